// File: doc/BRIEF.md
# Joinable Two-Channel Pulse-Width Modulator

This block produces two pulse-width modulated outputs from a shared set of registers. Each channel counts prescaled clock pulses against its own period value and compares the count with its own duty value. A channel can run left-aligned, where the counter ramps up and wraps, or center-aligned, where the counter ramps up to the period and back down so the active part of the waveform sits in the middle of each cycle. Each channel picks one of two prescaled clock-enable pulses as its count source and has a polarity bit that sets which level counts as active.

The two channels can also be joined into a single channel with a period and duty twice as wide. The even channel's registers then hold the upper byte and the odd channel's registers hold the lower byte. The odd channel's control bits govern the joined channel, and the waveform leaves on the odd output only. New period and duty values are double-buffered, so a running waveform never shows a partial period. Zero duty, zero period and duty at or above the period each give a fixed output level.

Top module: `pwm_pair_gen`

## Requirements
- R1: After reset both channels are disabled, the join bit and all period and duty registers are zero, every polarity bit is 0, and both outputs sit high.
- R2: Writes use `wr_addr`: 0 is the control register (bits 1:0 enable, bits 3:2 polarity, bits 5:4 clock select, bits 7:6 center-align, with the lower bit of each pair for channel 0). Address 1 bit 0 is the join bit. Addresses 2 and 3 are the periods of channels 0 and 1. Addresses 4 and 5 are their duties.
- R3: In left-aligned mode with period P > 0, the counter steps 0..P-1 and wraps. The output is at the polarity level while the count is below the duty D and at the opposite level otherwise.
- R4: In center-aligned mode with period P > 0, the counter steps 0,1..P,P-1..1 and repeats, so one cycle is 2P counts. The output is at the polarity level while the count is below D.
- R5: With duty zero the output stays at the inverse of the polarity bit, whatever the period.
- R6: With period zero and nonzero duty the counter holds at zero and the output stays at the polarity level.
- R7: With duty at or above the period the output stays at the polarity level, in both alignments and widths.
- R8: A clock-select bit of 0 makes the channel count on `tick_a` and a bit of 1 makes it count on `tick_b`. The counter does not move on the other pulse or with no pulse.
- R9: While a channel is enabled, new period or duty values take effect only when its cycle ends. While it is disabled they take effect at once.
- R10: A disabled channel drives the inverse of its polarity bit and clears its counter, so re-enabling it starts a fresh cycle at count zero.
- R11: With the join bit set, the 16-bit period is {period0, period1} and the 16-bit duty is {duty0, duty1}. Channel 1's enable, polarity, clock-select and align bits run it, and channel 0's align bit has no effect. Output 1 carries the waveform, and output 0 stays at the inverse of channel 0's polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for a write |
| wr_data | input | CH_W | Write data |
| tick_a | input | 1 | Prescaled count pulse, source A |
| tick_b | input | 1 | Prescaled count pulse, source B |
| pwm_out | output | 2 | Channel outputs, bit 1 is the odd channel |

## Verification
The bench checks the three fixed-level cases, including duty equal to the period in center-aligned mode. A design that compared with the count alone would drop the output for one count at the top of that ramp. It also rewrites the duty in the middle of a cycle, which exposes a design that loads new values early and cuts the running period. A long joined run checks the upper byte and the ignored even-channel align bit; swapping the byte order or taking the wrong align bit would fold the ramp too early. Pulses on the unselected clock source would shift every later sample if the design counted them.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
   localparam int NCH    = 2;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL      = 3'd0;
   localparam logic [ADDR_W-1:0] A_JOIN      = 3'd1;
   localparam logic [ADDR_W-1:0] A_PER_BASE  = 3'd2;
   localparam logic [ADDR_W-1:0] A_DUTY_BASE = 3'd4;

   // Control-word field offsets; each field holds one bit per channel.
   localparam int EN_LSB  = 0;
   localparam int POL_LSB = 2;
   localparam int SEL_LSB = 4;
   localparam int CEN_LSB = 6;
   localparam int CTRL_BITS = CEN_LSB + NCH;
endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
   import pwm_pair_pkg::*;
#(
   parameter int CH_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [CH_W-1:0]               wr_data,
   output logic [NCH-1:0]                en_q,
   output logic [NCH-1:0]                pol_q,
   output logic [NCH-1:0]                sel_q,
   output logic [NCH-1:0]                cen_q,
   output logic                          join_q,
   output logic [NCH-1:0][CH_W-1:0]      per_q,
   output logic [NCH-1:0][CH_W-1:0]      duty_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         pol_q  <= '0;
         sel_q  <= '0;
         cen_q  <= '0;
         join_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) begin
            en_q  <= wr_data[EN_LSB  +: NCH];
            pol_q <= wr_data[POL_LSB +: NCH];
            sel_q <= wr_data[SEL_LSB +: NCH];
            cen_q <= wr_data[CEN_LSB +: NCH];
         end
         if (wr_addr == A_JOIN) join_q <= wr_data[0];
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            per_q[c]  <= '0;
            duty_q[c] <= '0;
         end else if (wr_en) begin
            if (wr_addr == A_PER_BASE + ADDR_W'(c))  per_q[c]  <= wr_data;
            if (wr_addr == A_DUTY_BASE + ADDR_W'(c)) duty_q[c] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         en,
   input  logic         pol,
   input  logic         center,
   input  logic [W-1:0] per_in,
   input  logic [W-1:0] duty_in,
   output logic         out
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt;
   logic [W-1:0] per_a;
   logic [W-1:0] duty_a;
   logic         down;
   logic         active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         down   <= 1'b0;
         per_a  <= '0;
         duty_a <= '0;
      end else if (!en) begin
         cnt    <= '0;
         down   <= 1'b0;
         per_a  <= per_in;
         duty_a <= duty_in;
      end else if (tick) begin
         if (per_a == '0) begin
            cnt    <= '0;
            down   <= 1'b0;
            per_a  <= per_in;
            duty_a <= duty_in;
         end else if (!center) begin
            down <= 1'b0;
            if (cnt >= per_a - ONE) begin
               cnt    <= '0;
               per_a  <= per_in;
               duty_a <= duty_in;
            end else begin
               cnt <= cnt + ONE;
            end
         end else if (!down) begin
            cnt <= cnt + ONE;
            if (cnt + ONE >= per_a) down <= 1'b1;
         end else begin
            cnt <= cnt - ONE;
            if (cnt == ONE) begin
               down   <= 1'b0;
               per_a  <= per_in;
               duty_a <= duty_in;
            end
         end
      end
   end

   assign active = (duty_a != '0) && ((cnt < duty_a) || (duty_a >= per_a));
   assign out    = (en && active) ? pol : ~pol;
endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen
   import pwm_pair_pkg::*;
#(
   parameter int CH_W    = 8,
   parameter bit PAIRING = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [CH_W-1:0]   wr_data,
   input  logic              tick_a,
   input  logic              tick_b,
   output logic [1:0]        pwm_out
);
   localparam int WIDE_W = 2 * CH_W;

   if (CH_W < CTRL_BITS) begin : g_bad_width
      $error("CH_W must hold the control word");
   end

   logic [NCH-1:0]           en_q, pol_q, sel_q, cen_q;
   logic                     join_q;
   logic [NCH-1:0][CH_W-1:0] per_q, duty_q;
   logic                     join_eff;
   logic [NCH-1:0]           tick_sel;

   pwm_pair_regs #(.CH_W(CH_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .en_q(en_q), .pol_q(pol_q), .sel_q(sel_q),
      .cen_q(cen_q), .join_q(join_q), .per_q(per_q), .duty_q(duty_q)
   );

   assign join_eff = PAIRING ? join_q : 1'b0;

   for (genvar c = 0; c < NCH; c++) begin : g_tick
      assign tick_sel[c] = sel_q[c] ? tick_b : tick_a;
   end

   pwm_lane #(.W(CH_W)) u_lane_even (
      .clk(clk), .rst_n(rst_n), .tick(tick_sel[0]),
      .en(en_q[0] & ~join_eff), .pol(pol_q[0]), .center(cen_q[0]),
      .per_in(per_q[0]), .duty_in(duty_q[0]), .out(pwm_out[0])
   );

   if (PAIRING) begin : g_wide
      logic [WIDE_W-1:0] per_w, duty_w;
      assign per_w  = join_eff ? {per_q[0], per_q[1]}  : {{CH_W{1'b0}}, per_q[1]};
      assign duty_w = join_eff ? {duty_q[0], duty_q[1]} : {{CH_W{1'b0}}, duty_q[1]};
      pwm_lane #(.W(WIDE_W)) u_lane_odd (
         .clk(clk), .rst_n(rst_n), .tick(tick_sel[1]),
         .en(en_q[1]), .pol(pol_q[1]), .center(cen_q[1]),
         .per_in(per_w), .duty_in(duty_w), .out(pwm_out[1])
      );
   end else begin : g_narrow
      pwm_lane #(.W(CH_W)) u_lane_odd (
         .clk(clk), .rst_n(rst_n), .tick(tick_sel[1]),
         .en(en_q[1]), .pol(pol_q[1]), .center(cen_q[1]),
         .per_in(per_q[1]), .duty_in(duty_q[1]), .out(pwm_out[1])
      );
   end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       tick_a,
   input logic       tick_b,
   input logic [1:0] en_q,
   input logic [1:0] pol_q,
   input logic       join_q,
   input logic [1:0] pwm_out
);
   AST_RESET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (en_q == 2'b00 && !join_q && pwm_out == 2'b11)); // R1

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!wr_en && !tick_a && !tick_b) |-> $stable(pwm_out)); // R8

   AST_EVEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[0] |-> pwm_out[0] == ~pol_q[0]); // R10

   AST_ODD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[1] |-> pwm_out[1] == ~pol_q[1]); // R10

   AST_JOINED_EVEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      join_q |-> pwm_out[0] == ~pol_q[0]); // R11
endmodule

bind pwm_pair_gen pwm_pair_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick_a(tick_a), .tick_b(tick_b),
   .en_q(en_q), .pol_q(pol_q), .join_q(join_q), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_pair_gen.sv
module tb_pwm_pair_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tick_a = 1'b0;
   logic       tick_b = 1'b0;
   logic [1:0] pwm_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pwm_pair_gen dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick_a(tick_a), .tick_b(tick_b), .pwm_out(pwm_out)
   );

   // All tasks start and end on a falling edge.
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(input bit a, input bit b);
      tick_a = a; tick_b = b;
      @(negedge clk);
      tick_a = 1'b0; tick_b = 1'b0;
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic logic exp_lvl(bit center, bit pol, int per, int duty, int k);
      int cnt;
      int ph;
      bit act;
      if (per == 0) cnt = 0;
      else if (!center) cnt = k % per;
      else begin
         ph  = k % (2 * per);
         cnt = (ph <= per) ? ph : 2 * per - ph;
      end
      act = (duty != 0) && ((cnt < duty) || (duty >= per));
      return act ? pol : !pol;
   endfunction

   function automatic string tag(bit center, int per, int duty);
      if (duty == 0) return "R5";
      if (per == 0) return "R6";
      if (duty >= per) return "R7";
      return center ? "R4" : "R3";
   endfunction

   function automatic int pick_duty(int per);
      int r;
      r = int'($urandom % 4);
      if (r == 0) return 0;
      if (r == 1) return per + int'($urandom % 3);
      return int'($urandom % (per + 1));
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: idle after reset, ticks change nothing
      chk("R1", pwm_out[0], 1'b1);
      chk("R1", pwm_out[1], 1'b1);
      tick(1, 1); tick(1, 1);
      chk("R1", pwm_out[0], 1'b1);
      chk("R1", pwm_out[1], 1'b1);

      // R2: polarity field at bits 3:2 with channels disabled
      wr(3'd0, 8'h08);
      chk("R2", pwm_out[0], 1'b1);
      chk("R2", pwm_out[1], 1'b0);

      // R8: channel 0 on source B, left, per 4, duty 1, pol 1
      wr(3'd0, 8'h00);
      wr(3'd2, 8'd4); wr(3'd4, 8'd1);
      wr(3'd0, 8'h15);
      chk("R8", pwm_out[0], 1'b1);
      tick(1, 0);
      chk("R8", pwm_out[0], 1'b1);
      tick(0, 1);
      chk("R8", pwm_out[0], 1'b0);

      // R9: duty rewrite mid-cycle waits for the wrap
      wr(3'd0, 8'h00);
      wr(3'd2, 8'd4); wr(3'd4, 8'd2);
      wr(3'd0, 8'h05);
      chk("R9", pwm_out[0], 1'b1);
      tick(1, 1);
      wr(3'd4, 8'd4);
      chk("R9", pwm_out[0], 1'b1);
      tick(1, 1);
      chk("R9", pwm_out[0], 1'b0);
      tick(1, 1);
      chk("R9", pwm_out[0], 1'b0);
      tick(1, 1);
      chk("R9", pwm_out[0], 1'b1);
      tick(1, 1);
      chk("R9", pwm_out[0], 1'b1);

      // R10: disable forces idle level, re-enable restarts at count 0
      wr(3'd4, 8'd1);
      tick(1, 1); tick(1, 1);
      wr(3'd0, 8'h04);
      chk("R10", pwm_out[0], 1'b0);
      wr(3'd0, 8'h05);
      chk("R10", pwm_out[0], 1'b1);
      tick(1, 1);
      chk("R10", pwm_out[0], 1'b0);

      // Random independent channels (R3..R7; values written while disabled, R9)
      for (int n = 0; n < 40; n++) begin
         int per0, per1, duty0, duty1;
         bit pol0, pol1, cen0, cen1, sel0, sel1;
         per0 = int'($urandom % 9);  per1 = int'($urandom % 9);
         duty0 = pick_duty(per0);    duty1 = pick_duty(per1);
         pol0 = 1'($urandom); pol1 = 1'($urandom);
         cen0 = 1'($urandom); cen1 = 1'($urandom);
         sel0 = 1'($urandom); sel1 = 1'($urandom);
         wr(3'd0, 8'h00); wr(3'd1, 8'h00);
         wr(3'd2, 8'(per0));  wr(3'd3, 8'(per1));
         wr(3'd4, 8'(duty0)); wr(3'd5, 8'(duty1));
         wr(3'd0, {cen1, cen0, sel1, sel0, pol1, pol0, 2'b11});
         for (int k = 0; k < 24; k++) begin
            chk(tag(cen0, per0, duty0), pwm_out[0], exp_lvl(cen0, pol0, per0, duty0, k));
            chk(tag(cen1, per1, duty1), pwm_out[1], exp_lvl(cen1, pol1, per1, duty1, k));
            tick(1, 1);
         end
      end

      // Random joined configurations (R11)
      for (int n = 0; n < 12; n++) begin
         int hi, lo, per, duty;
         bit pol0, pol1, cen0, cen1;
         hi = int'($urandom % 2);
         lo = int'($urandom % 10);
         per = hi * 256 + lo;
         duty = (n % 3 == 0) ? 0 : (hi * 256 + int'($urandom % 12));
         pol0 = 1'($urandom); pol1 = 1'($urandom);
         cen0 = 1'($urandom); cen1 = 1'($urandom);
         wr(3'd0, 8'h00);
         wr(3'd1, 8'h01);
         wr(3'd2, 8'(hi));  wr(3'd3, 8'(lo));
         wr(3'd4, 8'(duty >> 8)); wr(3'd5, 8'(duty));
         wr(3'd0, {cen1, cen0, 2'b00, pol1, pol0, 2'b11});
         for (int k = 0; k < 24; k++) begin
            chk("R11", pwm_out[1], exp_lvl(cen1, pol1, per, duty, k));
            chk("R11", pwm_out[0], !pol0);
            tick(1, 1);
         end
      end

      // R11 directed: 258-count period, even align bit set but ignored
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h01);
      wr(3'd2, 8'h01); wr(3'd3, 8'h02);
      wr(3'd4, 8'h01); wr(3'd5, 8'h01);
      wr(3'd0, 8'h4B);
      for (int k = 0; k < 264; k++) begin
         chk("R11", pwm_out[1], exp_lvl(1'b0, 1'b1, 258, 257, k));
         chk("R11", pwm_out[0], 1'b1);
         tick(1, 1);
      end

      done = 1'b1;
      finish_run();
   end
endmodule